// File: doc/BRIEF.md
# Last-Line Buffer Front End for an Exclusion Cache

This block sits between an instruction fetch port and a direct-mapped cache whose lines hold several words and whose replacement is steered by a separate exclusion controller. It keeps one whole line and its tag in a side register. A fetch that falls inside that held line is answered from the register alone. Such a fetch does not look up the main cache and does not notify the exclusion controller, so a run of sequential fetches within one line counts as one reference.

A fetch outside the held line first looks up the main cache. On a hit, the returned line is loaded into the side register. On a miss, the line is requested from the refill port and always lands in the side register. In both cases the controller is then consulted exactly once. After a miss, its answer decides whether the line is also written into the main cache. An excluded line therefore costs one miss for all its words and never occupies a main-cache slot. A flush input invalidates the held line.

The sequencer has five states:
- IDLE: ready for a fetch.
- LOOKUP: main-cache probe.
- REFILL: wait for the line from the next level.
- DECIDE: controller consultation.
- RESPOND: one-cycle answer.

The transitions are:
- IDLE to RESPOND on an accepted fetch that matches the held line.
- IDLE to LOOKUP on an accepted fetch that does not match.
- LOOKUP to DECIDE on a cache hit.
- LOOKUP to REFILL on a cache miss.
- REFILL to DECIDE when the refill completes.
- DECIDE to RESPOND when the controller answers.
- RESPOND to IDLE always.

Top module: `last_line_buffer`

## Requirements
- R1: After reset the held line is invalid, `fetch_ready` is 1, and `resp_valid`, `lkp_valid`, `fill_req`, `dec_req` and `cwr_en` are 0. The first fetch after reset is always treated as a mismatch.
- R2: A fetch whose line tag (`fetch_addr` minus its low offset bits) equals the tag of a valid held line is answered with `resp_valid`=1 and `resp_from_buf`=1 in the cycle after acceptance. It issues no lookup, refill, controller request or cache write.
- R3: A fetch that does not match raises `lkp_valid` with `lkp_tag` equal to its line tag in the cycle after acceptance, and holds it until `lkp_done`.
- R4: On a lookup hit, the looked-up line is loaded into the held line and no refill is issued. `dec_req` is raised with `dec_was_hit`=1, and the response (`resp_from_buf`=0) follows one cycle after `dec_done`.
- R5: On a lookup miss, `fill_req` is raised with the line tag until `fill_done`. The refilled line is loaded into the held line, and `dec_req` with `dec_was_hit`=0 follows in the next cycle.
- R6: After a miss, `dec_keep`=1 makes `cwr_en` pulse for one cycle, together with the response, carrying the line tag and the refilled line. `dec_keep`=0 produces no write, yet later fetches to that line are served from the held line.
- R7: After a lookup hit, `dec_keep` is ignored and no cache write occurs.
- R8: The controller is consulted exactly once per mismatching fetch and never for a matching fetch.
- R9: The response word is bits [i*WORD_W +: WORD_W] of the held line, where i is the low $clog2(LINE_WORDS) bits of the fetch address.
- R10: A `flush` pulse invalidates the held line. The next fetch to the formerly held line is taken as a mismatch and issues a lookup.
- R11: `fetch_ready` is 0 from acceptance until the response cycle inclusive, so only one fetch is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate the held line |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_ready | output | 1 | Fetch accepted when high together with fetch_valid |
| resp_valid | output | 1 | Response word valid (one cycle) |
| resp_word | output | WORD_W | Fetched word |
| resp_from_buf | output | 1 | Response came from the held line without a lookup |
| lkp_valid | output | 1 | Main-cache lookup request |
| lkp_tag | output | TAG_W | Line tag to look up |
| lkp_done | input | 1 | Lookup answer present |
| lkp_hit | input | 1 | Lookup found the line |
| lkp_line | input | LINE_W | Line returned on a hit |
| fill_req | output | 1 | Refill request to the next level |
| fill_tag | output | TAG_W | Line tag to refill |
| fill_done | input | 1 | Refill data present |
| fill_line | input | LINE_W | Refilled line |
| dec_req | output | 1 | Exclusion controller consultation |
| dec_tag | output | TAG_W | Line tag presented to the controller |
| dec_was_hit | output | 1 | The reference hit in the main cache |
| dec_done | input | 1 | Controller answer present |
| dec_keep | input | 1 | Store the missing line in the main cache |
| cwr_en | output | 1 | Main-cache line write |
| cwr_tag | output | TAG_W | Tag of the written line |
| cwr_line | output | LINE_W | Line data written |

## Verification
With responders that answer in the cycle after each request, a matching fetch responds one cycle after the accepting edge. A lookup hit responds after three cycles and a miss after four. The cache write appears in the same cycle as the miss response. Inputs change and outputs are sampled on falling edges, so each latency is counted in whole cycles from the accepting edge. Request and write counters are read one cycle after the response, once the sequencer is back in IDLE and nothing can change them.

// File: rtl/llb_pkg.sv
package llb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REFILL,
        ST_DECIDE,
        ST_RESPOND
    } llb_state_e;

endpackage

// File: rtl/llb_line_store.sv
module llb_line_store #(
    parameter int TAG_W      = 14,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int OFF_W      = $clog2(LINE_WORDS),
    parameter int LINE_W     = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load_en,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [LINE_W-1:0] load_line,
    input  logic [TAG_W-1:0]  probe_tag,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              valid_o,
    output logic              match_o,
    output logic [WORD_W-1:0] word_o,
    output logic [LINE_W-1:0] line_o
);

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;

    // flush wins over a load in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (load_en) begin
            valid_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en) begin
            tag_q <= load_tag;
        end
    end

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (load_en) begin
                word_q <= load_line[w*WORD_W +: WORD_W];
            end
        end
        assign line_o[w*WORD_W +: WORD_W] = word_q;
    end

    assign valid_o = valid_q;
    assign match_o = valid_q && (tag_q == probe_tag);
    assign word_o  = line_o[rd_off*WORD_W +: WORD_W];

endmodule

// File: rtl/llb_seq_ctrl.sv
module llb_seq_ctrl
    import llb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 2,
    parameter int TAG_W  = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              buf_match,
    input  logic              lkp_done,
    input  logic              lkp_hit,
    input  logic              fill_done,
    input  logic              dec_done,
    input  logic              dec_keep,
    output logic              fetch_ready,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [OFF_W-1:0]  cur_off,
    output logic              lkp_valid,
    output logic              fill_req,
    output logic              dec_req,
    output logic              dec_was_hit,
    output logic              cwr_en,
    output logic              resp_valid,
    output logic              resp_from_buf,
    output logic              load_en,
    output logic              load_from_fill
);

    llb_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              hit_q;
    logic              keep_q;
    logic              from_buf_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && fetch_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (fetch_valid) state_d = buf_match ? ST_RESPOND : ST_LOOKUP;
            ST_LOOKUP:  if (lkp_done)    state_d = lkp_hit ? ST_DECIDE : ST_REFILL;
            ST_REFILL:  if (fill_done)   state_d = ST_DECIDE;
            ST_DECIDE:  if (dec_done)    state_d = ST_RESPOND;
            ST_RESPOND:                  state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            hit_q      <= 1'b0;
            keep_q     <= 1'b0;
            from_buf_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q     <= fetch_addr;
                from_buf_q <= buf_match;
                hit_q      <= 1'b0;
                keep_q     <= 1'b0;
            end
            if (state_q == ST_LOOKUP && lkp_done) begin
                hit_q <= lkp_hit;
            end
            if (state_q == ST_DECIDE && dec_done) begin
                keep_q <= dec_keep && !hit_q;
            end
        end
    end

    always_comb begin
        fetch_ready    = (state_q == ST_IDLE);
        lkp_valid      = (state_q == ST_LOOKUP);
        fill_req       = (state_q == ST_REFILL);
        dec_req        = (state_q == ST_DECIDE);
        resp_valid     = (state_q == ST_RESPOND);
        cwr_en         = (state_q == ST_RESPOND) && keep_q;
        load_en        = ((state_q == ST_LOOKUP) && lkp_done && lkp_hit)
                       || ((state_q == ST_REFILL) && fill_done);
        load_from_fill = (state_q == ST_REFILL);
        dec_was_hit    = hit_q;
        resp_from_buf  = from_buf_q;
        cur_tag        = addr_q[ADDR_W-1:OFF_W];
        cur_off        = addr_q[OFF_W-1:0];
    end

endmodule

// File: rtl/last_line_buffer.sv
module last_line_buffer #(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int OFF_W     = $clog2(LINE_WORDS),
    localparam int TAG_W     = ADDR_W - OFF_W,
    localparam int LINE_W    = WORD_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_word,
    output logic              resp_from_buf,
    output logic              lkp_valid,
    output logic [TAG_W-1:0]  lkp_tag,
    input  logic              lkp_done,
    input  logic              lkp_hit,
    input  logic [LINE_W-1:0] lkp_line,
    output logic              fill_req,
    output logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_done,
    input  logic [LINE_W-1:0] fill_line,
    output logic              dec_req,
    output logic [TAG_W-1:0]  dec_tag,
    output logic              dec_was_hit,
    input  logic              dec_done,
    input  logic              dec_keep,
    output logic              cwr_en,
    output logic [TAG_W-1:0]  cwr_tag,
    output logic [LINE_W-1:0] cwr_line
);

    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_off;
    logic              buf_valid;
    logic              buf_match;
    logic              load_en;
    logic              load_from_fill;
    logic [LINE_W-1:0] load_line;

    assign load_line = load_from_fill ? fill_line : lkp_line;

    llb_line_store #(
        .TAG_W      (TAG_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS),
        .OFF_W      (OFF_W),
        .LINE_W     (LINE_W)
    ) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .load_en   (load_en),
        .load_tag  (cur_tag),
        .load_line (load_line),
        .probe_tag (fetch_addr[ADDR_W-1:OFF_W]),
        .rd_off    (cur_off),
        .valid_o   (buf_valid),
        .match_o   (buf_match),
        .word_o    (resp_word),
        .line_o    (cwr_line)
    );

    llb_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .TAG_W  (TAG_W)
    ) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_valid    (fetch_valid),
        .fetch_addr     (fetch_addr),
        .buf_match      (buf_match),
        .lkp_done       (lkp_done),
        .lkp_hit        (lkp_hit),
        .fill_done      (fill_done),
        .dec_done       (dec_done),
        .dec_keep       (dec_keep),
        .fetch_ready    (fetch_ready),
        .cur_tag        (cur_tag),
        .cur_off        (cur_off),
        .lkp_valid      (lkp_valid),
        .fill_req       (fill_req),
        .dec_req        (dec_req),
        .dec_was_hit    (dec_was_hit),
        .cwr_en         (cwr_en),
        .resp_valid     (resp_valid),
        .resp_from_buf  (resp_from_buf),
        .load_en        (load_en),
        .load_from_fill (load_from_fill)
    );

    assign lkp_tag  = cur_tag;
    assign fill_tag = cur_tag;
    assign dec_tag  = cur_tag;
    assign cwr_tag  = cur_tag;

endmodule

// File: rtl/llb_checker.sv
module llb_checker (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic fetch_valid,
    input logic fetch_ready,
    input logic resp_valid,
    input logic resp_from_buf,
    input logic lkp_valid,
    input logic lkp_done,
    input logic lkp_hit,
    input logic fill_req,
    input logic dec_req,
    input logic dec_was_hit,
    input logic cwr_en,
    input logic buf_valid,
    input logic buf_match
);

    a_r1_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lkp_valid, fill_req, dec_req, resp_valid}));

    a_r2_buffer_serve: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && fetch_ready && buf_match |=> resp_valid && resp_from_buf);

    a_r3_lookup_held: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid && !lkp_done |=> lkp_valid);

    a_r4_hit_consults: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid && lkp_done && lkp_hit |=> dec_req && dec_was_hit && !fill_req);

    a_r5_miss_refills: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid && lkp_done && !lkp_hit |=> fill_req);

    a_r6_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        cwr_en |=> !cwr_en);

    a_r7_no_write_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        cwr_en |-> resp_valid && !dec_was_hit);

    a_r8_consult_after_probe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_req) |-> $past(lkp_valid) || $past(fill_req));

    a_r10_flush_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !buf_valid);

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid || fill_req || dec_req || resp_valid) |-> !fetch_ready);

endmodule

bind last_line_buffer llb_checker chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .fetch_valid   (fetch_valid),
    .fetch_ready   (fetch_ready),
    .resp_valid    (resp_valid),
    .resp_from_buf (resp_from_buf),
    .lkp_valid     (lkp_valid),
    .lkp_done      (lkp_done),
    .lkp_hit       (lkp_hit),
    .fill_req      (fill_req),
    .dec_req       (dec_req),
    .dec_was_hit   (dec_was_hit),
    .cwr_en        (cwr_en),
    .buf_valid     (buf_valid),
    .buf_match     (buf_match)
);

// File: tb/last_line_buffer_tb_top.sv
module last_line_buffer_tb_top;

    localparam int ADDR_W     = 16;
    localparam int WORD_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int OFF_W      = 2;
    localparam int TAG_W      = ADDR_W - OFF_W;
    localparam int LINE_W     = WORD_W * LINE_WORDS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_addr = '0;
    logic              fetch_ready, resp_valid, resp_from_buf;
    logic [WORD_W-1:0] resp_word;
    logic              lkp_valid, fill_req, dec_req, dec_was_hit, cwr_en;
    logic [TAG_W-1:0]  lkp_tag, fill_tag, dec_tag, cwr_tag;
    logic [LINE_W-1:0] cwr_line;
    logic              lkp_done = 1'b0, lkp_hit = 1'b0;
    logic [LINE_W-1:0] lkp_line = '0;
    logic              fill_done = 1'b0;
    logic [LINE_W-1:0] fill_line = '0;
    logic              dec_done = 1'b0, dec_keep = 1'b0;

    always #10 clk = ~clk;

    last_line_buffer #(
        .ADDR_W     (ADDR_W),
        .WORD_W     (WORD_W),
        .LINE_WORDS (LINE_WORDS)
    ) dut_i (.*);

    // responder models and counters
    logic [LINE_W-1:0] mc_mem [int];
    bit                keep_tbl [int];
    int                n_lkp = 0, n_fill = 0, n_dec = 0, n_cwr = 0;
    logic [TAG_W-1:0]  last_lkp_tag = '0, last_cwr_tag = '0;
    logic [LINE_W-1:0] last_cwr_line = '0;
    bit                last_dec_hit = 1'b0;

    int checks = 0;
    int failures = 0;

    function automatic logic [LINE_W-1:0] pat(input logic [3:0] kind, input logic [TAG_W-1:0] t);
        logic [LINE_W-1:0] l;
        for (int i = 0; i < LINE_WORDS; i++) begin
            l[i*WORD_W +: WORD_W] = {kind, 2'b00, t, 4'h0, 8'(i)};
        end
        return l;
    endfunction

    function automatic logic [WORD_W-1:0] wsel(input logic [LINE_W-1:0] l, input int off);
        return l[off*WORD_W +: WORD_W];
    endfunction

    always @(negedge clk) begin
        if (lkp_valid) begin
            n_lkp++;
            last_lkp_tag = lkp_tag;
        end
        if (fill_req) n_fill++;
        if (dec_req) begin
            n_dec++;
            last_dec_hit = dec_was_hit;
        end
        if (cwr_en) begin
            n_cwr++;
            last_cwr_tag  = cwr_tag;
            last_cwr_line = cwr_line;
            mc_mem[int'(cwr_tag)] = cwr_line;
        end
        lkp_done  = lkp_valid;
        lkp_hit   = lkp_valid && mc_mem.exists(int'(lkp_tag));
        lkp_line  = lkp_hit ? mc_mem[int'(lkp_tag)] : '0;
        fill_done = fill_req;
        fill_line = fill_req ? pat(4'hF, fill_tag) : '0;
        dec_done  = dec_req;
        dec_keep  = dec_req && keep_tbl.exists(int'(dec_tag));
    end

    task automatic chk(input string req, input string what, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one fetch; returns word, latency in cycles from the accepting edge, source, busy flag
    task automatic do_fetch(input logic [TAG_W-1:0] t, input int off,
                            output logic [WORD_W-1:0] word, output int lat,
                            output bit from_buf, output bit busy_ok);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_addr  = {t, OFF_W'(off)};
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!resp_valid && lat < 50) begin
            if (fetch_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (fetch_ready) busy_ok = 1'b0;
        word = resp_word;
        from_buf = resp_from_buf;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [WORD_W-1:0] w; int lat; bit fb, bz;
        @(negedge clk);
        chk("R1", "fetch_ready", LINE_W'(fetch_ready), 1);
        chk("R1", "idle outputs", LINE_W'({resp_valid, lkp_valid, fill_req, dec_req, cwr_en}), 0);
        do_fetch(14'h0010, 0, w, lat, fb, bz);
        chk("R1", "first fetch looks up", LINE_W'(n_lkp), 1);
    endtask

    task automatic t_miss_excluded;
        logic [WORD_W-1:0] w; int lat; bit fb, bz;
        int l0, f0, d0, c0;
        logic [TAG_W-1:0] t = 14'h0123;
        l0 = n_lkp; f0 = n_fill; d0 = n_dec; c0 = n_cwr;
        do_fetch(t, 0, w, lat, fb, bz);
        chk("R5", "miss latency", LINE_W'(lat), 4);
        chk("R5", "miss word", LINE_W'(w), LINE_W'(wsel(pat(4'hF, t), 0)));
        chk("R3", "lookup tag", LINE_W'(last_lkp_tag), LINE_W'(t));
        chk("R5", "refill count", LINE_W'(n_fill - f0), 1);
        chk("R5", "dec saw miss", LINE_W'(last_dec_hit), 0);
        chk("R6", "excluded no write", LINE_W'(n_cwr - c0), 0);
        chk("R11", "busy during miss", LINE_W'(bz), 1);
        for (int o = 1; o < LINE_WORDS; o++) begin
            do_fetch(t, o, w, lat, fb, bz);
            chk("R2", "buffer latency", LINE_W'(lat), 1);
            chk("R2", "from buffer", LINE_W'(fb), 1);
            chk("R9", "word select", LINE_W'(w), LINE_W'(wsel(pat(4'hF, t), o)));
        end
        chk("R8", "one consult per line run", LINE_W'(n_dec - d0), 1);
        chk("R2", "no lookup on buffer run", LINE_W'(n_lkp - l0), 1);
        chk("R6", "excluded line single miss", LINE_W'(n_fill - f0), 1);
    endtask

    task automatic t_miss_kept;
        logic [WORD_W-1:0] w; int lat; bit fb, bz;
        int f0, c0;
        logic [TAG_W-1:0] t = 14'h0200;
        keep_tbl[int'(t)] = 1'b1;
        c0 = n_cwr;
        do_fetch(t, 2, w, lat, fb, bz);
        chk("R6", "kept write count", LINE_W'(n_cwr - c0), 1);
        chk("R6", "write tag", LINE_W'(last_cwr_tag), LINE_W'(t));
        chk("R6", "write line", last_cwr_line, pat(4'hF, t));
        do_fetch(14'h0301, 0, w, lat, fb, bz);  // displace held line
        f0 = n_fill;
        do_fetch(t, 3, w, lat, fb, bz);
        chk("R4", "cache hit latency", LINE_W'(lat), 3);
        chk("R4", "cache hit not buffer", LINE_W'(fb), 0);
        chk("R4", "cache hit word", LINE_W'(w), LINE_W'(wsel(pat(4'hF, t), 3)));
        chk("R4", "no refill on hit", LINE_W'(n_fill - f0), 0);
        chk("R4", "dec saw hit", LINE_W'(last_dec_hit), 1);
    endtask

    task automatic t_hit_keep_ignored;
        logic [WORD_W-1:0] w; int lat; bit fb, bz;
        int c0, l0;
        logic [TAG_W-1:0] t = 14'h0044;
        mc_mem[int'(t)] = pat(4'hC, t);
        keep_tbl[int'(t)] = 1'b1;
        c0 = n_cwr;
        do_fetch(t, 1, w, lat, fb, bz);
        chk("R7", "no write on hit", LINE_W'(n_cwr - c0), 0);
        chk("R4", "hit line word", LINE_W'(w), LINE_W'(wsel(pat(4'hC, t), 1)));
        l0 = n_lkp;
        do_fetch(t, 2, w, lat, fb, bz);
        chk("R4", "hit line held", LINE_W'({fb, 8'(n_lkp - l0)}), LINE_W'({1'b1, 8'd0}));
        chk("R9", "held hit word", LINE_W'(w), LINE_W'(wsel(pat(4'hC, t), 2)));
    endtask

    task automatic t_flush;
        logic [WORD_W-1:0] w; int lat; bit fb, bz;
        int l0;
        logic [TAG_W-1:0] t = 14'h0044;
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        l0 = n_lkp;
        do_fetch(t, 0, w, lat, fb, bz);
        chk("R10", "lookup after flush", LINE_W'(n_lkp - l0), 1);
        chk("R10", "not from buffer", LINE_W'(fb), 0);
        chk("R10", "latency after flush", LINE_W'(lat), 3);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_excluded();
        t_miss_kept();
        t_hit_keep_ignored();
        t_flush();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule